// File: doc/BRIEF.md
# Byte-Wide Instruction Execute Stage

This block executes one 14-bit instruction word of a small 8-bit accumulator machine. Each transfer carries the instruction word, the current accumulator (W) value, the operand byte the fetch logic has already read from the register file, and the incoming carry flag. The block returns a result byte and says where that byte goes: W or the register file. It also returns new carry, digit-carry and zero flags, each with its own update enable, and a flag that tells the sequencer to skip the next instruction. The program counter, the call stack, register-file storage, and power or watchdog handling belong to other blocks.

Both sides of the block are valid/ready streams, with one register stage between them. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output one cycle later and stays there until `out_ready` is high on an edge. `in_ready` is high when the output register is empty or is being drained in that same cycle, so back-pressure from the output reaches the input without a cycle of delay. Results leave in the order their words arrived.

Top module: `byte_exec_unit`

## Requirements
- R1: For byte-oriented words (bits 13:12 = 00, opcode in bits 13:8), bit 7 picks the target: 0 writes W and 1 writes the file register. The address field in bits 6:0 has no effect on any output. Opcode 0x00 with bit 7 = 1 copies W into the file register and changes no flags.
- R2: Add (opcode 0x07) gives f+W modulo 256. It sets C to the carry out of bit 7, DC to the carry out of bit 3, and Z, and enables all three flags.
- R3: Subtract (opcode 0x02) gives f−W modulo 256. C = 1 when no borrow occurs (f ≥ W). DC = 1 when no borrow occurs out of bit 3. Z is set, and all three flags are enabled.
- R4: These operations enable only Z, and Z = 1 exactly when the result is zero:
  - IOR 0x04, AND 0x05 and XOR 0x06 of f with W;
  - complement 0x09;
  - decrement 0x03 and increment 0x0A;
  - move-file 0x08;
  - clear-file, which is 0x01 with bit 7 = 1 and gives result 0 to the file register;
  - clear-W, which is exactly the word 0x0100 and gives result 0 to W.
- R5: Rotate-right (0x0C) and rotate-left (0x0D) pass through carry and enable only C. Rotate-left moves the old C into bit 0 and bit 7 into C. Rotate-right moves the old C into bit 7 and bit 0 into C.
- R6: Nibble swap (0x0E) exchanges bits 7:4 with bits 3:0 and enables no flag. Decrement-skip (0x0B) and increment-skip (0x0F) write f−1 or f+1, enable no flag, and raise skip when that result is zero.
- R7: Bit clear and bit set (bits 13:10 = 0100 and 0101) write f to the file register with the bit given by bits 9:7 cleared or set. No flag is enabled.
- R8: Bit tests (bits 13:10 = 0110 for skip-if-clear and 0111 for skip-if-set) raise skip when the bit of f given by bits 9:7 is 0 or 1 respectively. They write nothing and enable no flag.
- R9: Literal words carry an 8-bit literal in bits 7:0 and always write W. Prefix 0x30 loads the literal, 0x34 loads it for a return, 0x38 ORs it with W, and 0x39 ANDs it with W. Only OR and AND enable Z.
- R10: Any other word is a no-operation: no write, no flag enable and no skip. This covers bits 13:12 = 10, opcode 0x00 or 0x01 with bit 7 = 0 other than 0x0100, and any other literal prefix.
- R11: When the write enable is low, the result and the target select are 0. When a flag's enable is low, that flag's value is 0.
- R12: `in_ready` = !`out_valid` || `out_ready`. A result that is held under back-pressure does not change. Every accepted word produces exactly one result, in order.
- R13: While `rst_n` is low, and until a word is accepted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_instr | input | 14 | Instruction word |
| in_wreg | input | 8 | Current W value |
| in_fbyte | input | 8 | Operand byte read from the file register |
| in_carry | input | 1 | Current C flag |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Result byte |
| out_to_file | output | 1 | 1 = write file register, 0 = write W |
| out_wr_en | output | 1 | Result must be written |
| out_c | output | 1 | New carry value |
| out_dc | output | 1 | New digit-carry value |
| out_z | output | 1 | New zero value |
| out_c_en | output | 1 | Update C |
| out_dc_en | output | 1 | Update DC |
| out_z_en | output | 1 | Update Z |
| out_skip | output | 1 | Skip the next instruction |

## Verification
The assertions check some rules on every cycle:
- a stalled output stays stable and the input is refused while it is stalled;
- Z agrees with the result byte whenever Z is enabled;
- DC is never enabled without C and Z;
- a disabled flag or write reads zero;
- a skip never comes with a flag update.

The exact arithmetic of each operation cannot be shown by a per-cycle property, and needs the bench's scenarios. That covers the carries out of bits 3 and 7, the rotate and swap bit movement, the bit-index selection, the literal prefixes, the undefined words, and the ordering of results under random back-pressure.

// File: rtl/byte_exec_pkg.sv
package byte_exec_pkg;
  localparam int DW  = 8;
  localparam int IW  = 14;
  localparam int BIW = $clog2(DW);

  typedef enum logic [4:0] {
    OP_NOP, OP_MOVWF, OP_CLR, OP_SUB, OP_DEC, OP_IOR, OP_AND, OP_XOR,
    OP_ADD, OP_MOVF, OP_COM, OP_INC, OP_DECSZ, OP_RR, OP_RL, OP_SWAP,
    OP_INCSZ, OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS, OP_LMOV, OP_LIOR,
    OP_LAND, OP_LRET
  } op_e;

  typedef struct packed {
    op_e            op;
    logic           to_file;
    logic           wen;
    logic           c_en;
    logic           dc_en;
    logic           z_en;
    logic [BIW-1:0] bidx;
    logic [DW-1:0]  lit;
  } dec_t;

  typedef struct packed {
    logic [DW-1:0] result;
    logic          to_file;
    logic          wen;
    logic          c;
    logic          dc;
    logic          z;
    logic          c_en;
    logic          dc_en;
    logic          z_en;
    logic          skip;
  } res_t;
endpackage

// File: rtl/byte_exec_decode.sv
module byte_exec_decode
  import byte_exec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          dec
);
  logic [5:0] opc;
  logic       dbit;
  op_e        op;

  assign opc  = instr[IW-1:IW-6];
  assign dbit = instr[7];

  always_comb begin
    op = OP_NOP;
    unique case (instr[IW-1:IW-2])
      2'b00: begin
        case (opc[3:0])
          4'h0: op = dbit ? OP_MOVWF : OP_NOP;
          4'h1: op = (dbit || instr[6:0] == 7'd0) ? OP_CLR : OP_NOP;
          4'h2: op = OP_SUB;
          4'h3: op = OP_DEC;
          4'h4: op = OP_IOR;
          4'h5: op = OP_AND;
          4'h6: op = OP_XOR;
          4'h7: op = OP_ADD;
          4'h8: op = OP_MOVF;
          4'h9: op = OP_COM;
          4'hA: op = OP_INC;
          4'hB: op = OP_DECSZ;
          4'hC: op = OP_RR;
          4'hD: op = OP_RL;
          4'hE: op = OP_SWAP;
          default: op = OP_INCSZ;
        endcase
      end
      2'b01: begin
        case (instr[11:10])
          2'b00: op = OP_BCLR;
          2'b01: op = OP_BSET;
          2'b10: op = OP_BTSC;
          default: op = OP_BTSS;
        endcase
      end
      2'b11: begin
        case (opc)
          6'h30: op = OP_LMOV;
          6'h34: op = OP_LRET;
          6'h38: op = OP_LIOR;
          6'h39: op = OP_LAND;
          default: op = OP_NOP;
        endcase
      end
      default: op = OP_NOP;
    endcase
  end

  always_comb begin
    dec.op      = op;
    dec.bidx    = instr[9:7];
    dec.lit     = instr[DW-1:0];
    dec.wen     = !(op inside {OP_NOP, OP_BTSC, OP_BTSS});
    dec.c_en    = op inside {OP_ADD, OP_SUB, OP_RR, OP_RL};
    dec.dc_en   = op inside {OP_ADD, OP_SUB};
    dec.z_en    = op inside {OP_ADD, OP_SUB, OP_CLR, OP_DEC, OP_IOR, OP_AND,
                             OP_XOR, OP_MOVF, OP_COM, OP_INC, OP_LIOR, OP_LAND};
    if (op inside {OP_MOVWF, OP_BCLR, OP_BSET})
      dec.to_file = 1'b1;
    else if (op inside {OP_NOP, OP_BTSC, OP_BTSS, OP_LMOV, OP_LRET, OP_LIOR, OP_LAND})
      dec.to_file = 1'b0;
    else
      dec.to_file = dbit;
  end
endmodule

// File: rtl/byte_exec_alu.sv
module byte_exec_alu
  import byte_exec_pkg::*;
(
  input  dec_t          dec,
  input  logic [DW-1:0] wreg,
  input  logic [DW-1:0] fbyte,
  input  logic          cin,
  output res_t          res
);
  localparam int HW = DW / 2;

  logic [DW:0]   sum_full, dif_full;
  logic [HW:0]   sum_half, dif_half;
  logic [DW-1:0] r, bit_mask;
  logic          c_raw, dc_raw, skip_raw;

  assign sum_full = {1'b0, fbyte} + {1'b0, wreg};
  assign dif_full = {1'b0, fbyte} + {1'b0, ~wreg} + 1'b1;
  assign sum_half = {1'b0, fbyte[HW-1:0]} + {1'b0, wreg[HW-1:0]};
  assign dif_half = {1'b0, fbyte[HW-1:0]} + {1'b0, ~wreg[HW-1:0]} + 1'b1;
  assign bit_mask = DW'(1) << dec.bidx;

  always_comb begin
    r        = '0;
    c_raw    = 1'b0;
    dc_raw   = 1'b0;
    skip_raw = 1'b0;
    case (dec.op)
      OP_MOVWF: r = wreg;
      OP_CLR:   r = '0;
      OP_SUB:   begin r = dif_full[DW-1:0]; c_raw = dif_full[DW]; dc_raw = dif_half[HW]; end
      OP_ADD:   begin r = sum_full[DW-1:0]; c_raw = sum_full[DW]; dc_raw = sum_half[HW]; end
      OP_DEC:   r = fbyte - 1'b1;
      OP_INC:   r = fbyte + 1'b1;
      OP_DECSZ: begin r = fbyte - 1'b1; skip_raw = (r == '0); end
      OP_INCSZ: begin r = fbyte + 1'b1; skip_raw = (r == '0); end
      OP_IOR:   r = fbyte | wreg;
      OP_AND:   r = fbyte & wreg;
      OP_XOR:   r = fbyte ^ wreg;
      OP_MOVF:  r = fbyte;
      OP_COM:   r = ~fbyte;
      OP_RR:    begin r = {cin, fbyte[DW-1:1]}; c_raw = fbyte[0]; end
      OP_RL:    begin r = {fbyte[DW-2:0], cin}; c_raw = fbyte[DW-1]; end
      OP_SWAP:  r = {fbyte[HW-1:0], fbyte[DW-1:HW]};
      OP_BCLR:  r = fbyte & ~bit_mask;
      OP_BSET:  r = fbyte | bit_mask;
      OP_BTSC:  skip_raw = ((fbyte & bit_mask) == '0);
      OP_BTSS:  skip_raw = ((fbyte & bit_mask) != '0);
      OP_LMOV,
      OP_LRET:  r = dec.lit;
      OP_LIOR:  r = dec.lit | wreg;
      OP_LAND:  r = dec.lit & wreg;
      default:  r = '0;
    endcase
  end

  always_comb begin
    res.result  = dec.wen ? r : '0;
    res.to_file = dec.wen & dec.to_file;
    res.wen     = dec.wen;
    res.c       = dec.c_en & c_raw;
    res.dc      = dec.dc_en & dc_raw;
    res.z       = dec.z_en & ~|r;
    res.c_en    = dec.c_en;
    res.dc_en   = dec.dc_en;
    res.z_en    = dec.z_en;
    res.skip    = skip_raw;
  end
endmodule

// File: rtl/byte_exec_stage.sv
module byte_exec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full;
  logic [W-1:0] hold;

  assign in_ready  = !full || out_ready;
  assign out_valid = full;
  assign out_data  = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else begin
      if (in_ready) full <= in_valid;
      if (in_valid && in_ready) hold <= in_data;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R12
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
  import byte_exec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_instr,
  input  logic [DW-1:0] in_wreg,
  input  logic [DW-1:0] in_fbyte,
  input  logic          in_carry,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_to_file,
  output logic          out_wr_en,
  output logic          out_c,
  output logic          out_dc,
  output logic          out_z,
  output logic          out_c_en,
  output logic          out_dc_en,
  output logic          out_z_en,
  output logic          out_skip
);
  localparam int RW = $bits(res_t);

  dec_t dec;
  res_t comb_res, reg_res;

  byte_exec_decode u_dec (.instr(in_instr), .dec(dec));

  byte_exec_alu u_alu (
    .dec(dec), .wreg(in_wreg), .fbyte(in_fbyte), .cin(in_carry), .res(comb_res)
  );

  byte_exec_stage #(.W(RW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(comb_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(reg_res)
  );

  assign out_result  = reg_res.result;
  assign out_to_file = reg_res.to_file;
  assign out_wr_en   = reg_res.wen;
  assign out_c       = reg_res.c;
  assign out_dc      = reg_res.dc;
  assign out_z       = reg_res.z;
  assign out_c_en    = reg_res.c_en;
  assign out_dc_en   = reg_res.dc_en;
  assign out_z_en    = reg_res.z_en;
  assign out_skip    = reg_res.skip;

  AST_FULL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R12
  AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_z_en && out_wr_en |-> out_z == (out_result == '0)); // R4
  AST_DC_ONLY_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dc_en |-> out_c_en && out_z_en); // R2
  AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_c_en || !out_c) && (out_dc_en || !out_dc) && (out_z_en || !out_z)); // R11
  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wr_en |-> out_result == '0 && !out_to_file); // R11
  AST_SKIP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_skip |-> !out_c_en && !out_dc_en && !out_z_en); // R8
  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R13
endmodule

// File: tb/tb_byte_exec_unit.sv
module tb_byte_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, in_carry, out_valid, out_ready;
  logic [13:0] in_instr;
  logic [7:0]  in_wreg, in_fbyte, out_result;
  logic        out_to_file, out_wr_en, out_c, out_dc, out_z;
  logic        out_c_en, out_dc_en, out_z_en, out_skip;

  int errors = 0;
  int checks = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_wreg(in_wreg), .in_fbyte(in_fbyte), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_to_file(out_to_file), .out_wr_en(out_wr_en), .out_c(out_c), .out_dc(out_dc),
    .out_z(out_z), .out_c_en(out_c_en), .out_dc_en(out_dc_en), .out_z_en(out_z_en),
    .out_skip(out_skip)
  );

  // Behavioural reference: returns {result,to_file,wen,c,dc,z,c_en,dc_en,z_en,skip}
  function automatic logic [16:0] model(input logic [13:0] i, input int w, input int f,
                                         input int c, output string tag);
    int res = 0, op = i[13:8], b = i[9:7];
    bit tf = 0, we = 0, cc = 0, dd = 0, ce = 0, de = 0, ze = 0, sk = 0;
    tag = "R10";
    if (i[13:12] == 2'b00) begin
      we = 1; tf = i[7]; tag = "R4";
      case (op)
        0:  if (i[7]) begin res = w; tag = "R1"; end else we = 0;
        1:  if (i[7] || i == 14'h0100) begin res = 0; ze = 1; end else we = 0;
        2:  begin res = (f - w) & 255; cc = (f >= w); dd = ((f % 16) >= (w % 16));
              ce = 1; de = 1; ze = 1; tag = "R3"; end
        3:  begin res = (f + 255) % 256; ze = 1; end
        4:  begin res = f | w; ze = 1; end
        5:  begin res = f & w; ze = 1; end
        6:  begin res = f ^ w; ze = 1; end
        7:  begin res = (f + w) % 256; cc = (f + w > 255); dd = ((f % 16) + (w % 16) > 15);
              ce = 1; de = 1; ze = 1; tag = "R2"; end
        8:  begin res = f; ze = 1; end
        9:  begin res = 255 - f; ze = 1; end
        10: begin res = (f + 1) % 256; ze = 1; end
        11: begin res = (f + 255) % 256; sk = (res == 0); tag = "R6"; end
        12: begin res = f / 2 + 128 * c; cc = f % 2; ce = 1; tag = "R5"; end
        13: begin res = (f * 2) % 256 + c; cc = f / 128; ce = 1; tag = "R5"; end
        14: begin res = (f % 16) * 16 + f / 16; tag = "R6"; end
        default: begin res = (f + 1) % 256; sk = (res == 0); tag = "R6"; end
      endcase
      if (!we) begin tf = 0; tag = "R10"; end
    end else if (i[13:12] == 2'b01) begin
      case (i[11:10])
        2'b00: begin we = 1; tf = 1; res = f & ~(1 << b) & 255; tag = "R7"; end
        2'b01: begin we = 1; tf = 1; res = f | (1 << b); tag = "R7"; end
        2'b10: begin sk = ((f >> b) % 2 == 0); tag = "R8"; end
        default: begin sk = ((f >> b) % 2 == 1); tag = "R8"; end
      endcase
    end else if (i[13:12] == 2'b11) begin
      tag = "R9";
      case (op)
        'h30, 'h34: begin we = 1; res = i[7:0]; end
        'h38: begin we = 1; res = i[7:0] | w; ze = 1; end
        'h39: begin we = 1; res = i[7:0] & w; ze = 1; end
        default: tag = "R10";
      endcase
    end
    return {8'(res), tf, we, cc & ce, dd & de, ze & (res == 0), ce, de, ze, sk};
  endfunction

  task automatic check_out();
    logic [16:0] got;
    checks++;
    if (out_valid !== (exp_q.size() != 0)) begin
      errors++;
      $display("FAIL R12 out_valid actual=%b expected=%b", out_valid, exp_q.size() != 0);
    end else if (out_valid) begin
      got = {out_result, out_to_file, out_wr_en, out_c, out_dc, out_z,
             out_c_en, out_dc_en, out_z_en, out_skip};
      if (got !== exp_q[0]) begin
        errors++;
        $display("FAIL %s result/flags actual=%h expected=%h", tag_q[0], got, exp_q[0]);
      end
    end
  endtask

  // one negedge step: check outputs, choose ready, account handshakes
  task automatic step(output bit accepted);
    check_out();
    out_ready = ($urandom % 4) != 0;
    #1;
    if (out_valid && out_ready) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
    accepted = in_valid && in_ready;
  endtask

  task automatic send(input logic [13:0] i, input logic [7:0] w, input logic [7:0] f,
                      input logic c);
    bit acc = 0;
    string t;
    logic [16:0] e;
    if ($urandom % 5 == 0) begin
      @(negedge clk); in_valid = 0; step(acc);
    end
    e = model(i, w, f, c, t);
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid = 1; in_instr = i; in_wreg = w; in_fbyte = f; in_carry = c;
      step(acc);
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    rst_n = 0; in_valid = 0; out_ready = 0;
    in_instr = '0; in_wreg = '0; in_fbyte = '0; in_carry = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R13 out_valid actual=%b expected=0", out_valid);
    end
    rst_n = 1;
    // R2 add corners, R3 subtract borrow corners
    send(14'h078C, 8'h01, 8'hFF, 0); send(14'h070C, 8'h08, 8'h08, 0);
    send(14'h070C, 8'h00, 8'h00, 1); send(14'h020C, 8'h05, 8'h05, 0);
    send(14'h028C, 8'h06, 8'h05, 1); send(14'h020C, 8'h01, 8'h10, 0);
    // R4 Z-only ops, clears, R1 move-W-to-file and address independence
    send(14'h0100, 8'h55, 8'h66, 1); send(14'h01FF, 8'h55, 8'h66, 1);
    send(14'h0A8C, 8'h00, 8'hFF, 0); send(14'h030C, 8'h00, 8'h01, 0);
    send(14'h0900, 8'h00, 8'hFF, 0); send(14'h00A3, 8'h5A, 8'h00, 0);
    send(14'h0540, 8'h0F, 8'hF0, 0); send(14'h0640, 8'hAA, 8'hAA, 0);
    // R5 rotates through carry, R6 swap and skip-on-zero
    send(14'h0D8C, 8'h00, 8'h80, 1); send(14'h0C0C, 8'h00, 8'h01, 0);
    send(14'h0C0C, 8'h00, 8'h00, 1); send(14'h0E8C, 8'h00, 8'hA5, 0);
    send(14'h0B8C, 8'h00, 8'h01, 0); send(14'h0F0C, 8'h00, 8'hFF, 0);
    send(14'h0F0C, 8'h00, 8'h10, 0);
    // R7 bit set/clear, R8 bit tests on both polarities
    send(14'h138C, 8'h00, 8'hFF, 0); send(14'h140C, 8'h00, 8'h00, 0);
    send(14'h1A0C, 8'h00, 8'hEF, 0); send(14'h1A0C, 8'h00, 8'h10, 0);
    send(14'h1E8C, 8'h00, 8'h20, 0); send(14'h1C0C, 8'h00, 8'hFE, 0);
    // R9 literals, R10 undefined words
    send(14'h3073, 8'h11, 8'h00, 0); send(14'h347F, 8'h00, 8'h00, 0);
    send(14'h3873, 8'h80, 8'h00, 0); send(14'h3900, 8'hFF, 8'h00, 1);
    send(14'h3A15, 8'h11, 8'h22, 1); send(14'h2800, 8'h11, 8'h22, 1);
    send(14'h0064, 8'h11, 8'h22, 1); send(14'h0105, 8'h11, 8'h22, 1);
    // R11/R12 random mix under random back-pressure
    for (int k = 0; k < N_RANDOM; k++)
      send(14'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    // drain
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) begin
      @(negedge clk); in_valid = 0; step(acc);
    end
    @(negedge clk); in_valid = 0; check_out();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule